// File: doc/BRIEF.md
# Nibble Accumulator Datapath with Carry and Zero-Result Flags

This block is the 4-bit arithmetic core of a small accumulator machine. It holds a single accumulator register and a two-bit flags register (carry and equal). A shared data bus, modelled as a multiplexer in place of tri-state drivers, carries one of four values: the immediate nibble of the current instruction, read data from data memory, an input-port value, or the ALU result. The ALU always takes the accumulator as its first operand and the bus as its second.

An external sequencer drives the control inputs: the ALU function, an active-low carry-in, separate load enables for the accumulator and the flags, and the bus-source select. The ALU carry-in always comes from the active-low control input and never from the stored carry flag. A decoder may therefore tie the carry-in control to opcode bit 3 and the arithmetic/logic choice to opcode bit 2. Compare subtracts the operand from the accumulator and updates only the flags. NOR is the only logic function. Loads of an immediate, a memory nibble or an input port pass the bus value through to the accumulator and leave the flags untouched. For stores, the ALU result is placed on the bus. The ALU's second operand is then forced to zero, so the bus value depends only on the accumulator and never feeds back on itself.

Top module: `nib_datapath`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release, the accumulator, carry flag and equal flag all read 0 until the first load.
- R2: bus_sel_i selects the bus value: 0 = immediate nibble, 1 = memory read data, 2 = input port. With one of these selected, bus_o equals that source in the same cycle.
- R3: alu_fn_i = 0 (add): the result is acc + bus + cin (modulo 16), where cin = NOT carry_in_n_i. The carry is bit 4 of the 5-bit sum.
- R4: alu_fn_i = 1 (compare): the result is acc + (NOT bus) + cin. The carry is bit 4 of that sum, so with cin = 1 a carry of 1 means acc >= operand. The accumulator does not change, even with acc_load_i high.
- R5: alu_fn_i = 2 (NOR): the result is NOT(acc OR bus), and the carry produced is 0.
- R6: alu_fn_i = 3 (pass): the result equals the bus operand, so a load of an immediate, memory or port value copies that value into the accumulator.
- R7: When flags_load_i is high at a clock edge, the equal flag becomes 1 exactly when the 4-bit ALU result is zero, and the carry flag takes the ALU carry.
- R8: When flags_load_i is low at a clock edge, both flags keep their values.
- R9: When acc_load_i is low at a clock edge, the accumulator keeps its value. When it is high and the function is not compare, the accumulator takes the ALU result.
- R10: bus_sel_i = 3 (store): the ALU's second operand is forced to 0 and bus_o shows the ALU result. With add and carry_in_n_i = 1, bus_o equals the accumulator.
- R11: A stored carry flag of 1 has no effect on an add done with carry_in_n_i = 1. The sum is acc + operand only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imm_i | input | 4 | Immediate nibble from the instruction |
| mem_rdata_i | input | 4 | Data-memory read nibble |
| port_i | input | 4 | Input-port nibble |
| alu_fn_i | input | 2 | ALU function: 0 add, 1 compare, 2 NOR, 3 pass |
| carry_in_n_i | input | 1 | Active-low ALU carry-in |
| acc_load_i | input | 1 | Accumulator load enable |
| flags_load_i | input | 1 | Flags load enable |
| bus_sel_i | input | 2 | Bus source: 0 immediate, 1 memory, 2 port, 3 ALU result |
| bus_o | output | 4 | Data bus value, used as store data |
| acc_o | output | 4 | Accumulator contents |
| carry_o | output | 1 | Stored carry flag |
| equal_o | output | 1 | Stored equal (zero-result) flag |

## Verification
On every cycle, the assertions check that the accumulator holds when its load is off or a compare runs. They also check that the flags hold without their enable, that the equal flag matches a zero ALU result, that NOR leaves carry clear, and that a plain store puts the accumulator on the bus. Only the bench's sweeps can show the arithmetic itself. These cover every accumulator and operand pair under each function and carry-in setting, including the borrow sense of compare and the fact that a set carry flag does not leak into the next add.

// File: rtl/nib_dp_pkg.sv
package nib_dp_pkg;

    localparam int unsigned NIB_W = 4;

    typedef enum logic [1:0] {
        FN_ADD  = 2'd0,
        FN_CMP  = 2'd1,
        FN_NOR  = 2'd2,
        FN_PASS = 2'd3
    } alu_fn_e;

    typedef enum logic [1:0] {
        SRC_IMM  = 2'd0,
        SRC_MEM  = 2'd1,
        SRC_PORT = 2'd2,
        SRC_ALU  = 2'd3
    } bus_src_e;

endpackage

// File: rtl/nib_bus_mux.sv
module nib_bus_mux
    import nib_dp_pkg::*;
#(
    parameter int unsigned W = NIB_W
) (
    input  bus_src_e       sel,
    input  logic [W-1:0]   imm,
    input  logic [W-1:0]   mem,
    input  logic [W-1:0]   port,
    input  logic [W-1:0]   alu_res,
    output logic [W-1:0]   operand_b,
    output logic [W-1:0]   bus
);

    logic [W-1:0] ext_val;

    always_comb begin
        ext_val = '0;
        unique case (sel)
            SRC_IMM:  ext_val = imm;
            SRC_MEM:  ext_val = mem;
            SRC_PORT: ext_val = port;
            SRC_ALU:  ext_val = '0;
        endcase
    end

    // During a store the ALU sees zero as its operand, which breaks the loop.
    assign operand_b = (sel == SRC_ALU) ? '0 : ext_val;
    assign bus       = (sel == SRC_ALU) ? alu_res : ext_val;

endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_dp_pkg::*;
#(
    parameter int unsigned W = NIB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);

    localparam int unsigned SW = W + 1;

    logic [SW-1:0] sum;
    logic [SW-1:0] cin_ext;

    assign cin_ext = {{W{1'b0}}, cin};

    always_comb begin
        sum = '0;
        unique case (fn)
            FN_ADD:  sum = {1'b0, a} + {1'b0, b} + cin_ext;
            FN_CMP:  sum = {1'b0, a} + {1'b0, ~b} + cin_ext;
            FN_NOR:  sum = {1'b0, ~(a | b)};
            FN_PASS: sum = {1'b0, b};
        endcase
    end

    assign res  = sum[W-1:0];
    assign cout = sum[W];

endmodule

// File: rtl/nib_dp_regs.sv
module nib_dp_regs #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_we,
    input  logic         flag_we,
    input  logic [W-1:0] acc_d,
    input  logic         carry_d,
    input  logic         equal_d,
    output logic [W-1:0] acc_q,
    output logic         carry_q,
    output logic         equal_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_we) begin
            acc_q <= acc_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            equal_q <= 1'b0;
        end else if (flag_we) begin
            carry_q <= carry_d;
            equal_q <= equal_d;
        end
    end

endmodule

// File: rtl/nib_datapath.sv
module nib_datapath
    import nib_dp_pkg::*;
#(
    parameter int unsigned W = NIB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] imm_i,
    input  logic [W-1:0] mem_rdata_i,
    input  logic [W-1:0] port_i,
    input  logic [1:0]   alu_fn_i,
    input  logic         carry_in_n_i,
    input  logic         acc_load_i,
    input  logic         flags_load_i,
    input  logic [1:0]   bus_sel_i,
    output logic [W-1:0] bus_o,
    output logic [W-1:0] acc_o,
    output logic         carry_o,
    output logic         equal_o
);

    alu_fn_e      fn;
    bus_src_e     src;
    logic [W-1:0] operand_b;
    logic [W-1:0] alu_res;
    logic         alu_cout;
    logic         acc_we;
    logic         res_zero;

    assign fn  = alu_fn_e'(alu_fn_i);
    assign src = bus_src_e'(bus_sel_i);

    nib_bus_mux #(.W(W)) u_mux (
        .sel       (src),
        .imm       (imm_i),
        .mem       (mem_rdata_i),
        .port      (port_i),
        .alu_res   (alu_res),
        .operand_b (operand_b),
        .bus       (bus_o)
    );

    nib_alu #(.W(W)) u_alu (
        .a    (acc_o),
        .b    (operand_b),
        .fn   (fn),
        .cin  (~carry_in_n_i),
        .res  (alu_res),
        .cout (alu_cout)
    );

    // Compare never writes the accumulator.
    assign acc_we   = acc_load_i && (fn != FN_CMP);
    assign res_zero = (alu_res == '0);

    nib_dp_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_we  (acc_we),
        .flag_we (flags_load_i),
        .acc_d   (alu_res),
        .carry_d (alu_cout),
        .equal_d (res_zero),
        .acc_q   (acc_o),
        .carry_q (carry_o),
        .equal_q (equal_o)
    );

    assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_load_i |=> $stable(acc_o));

    assert_cmp_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn_i == 2'd1) |=> $stable(acc_o));

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_load_i |=> ($stable(carry_o) && $stable(equal_o)));

    assert_equal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_load_i |=> (equal_o == ($past(alu_res) == '0)));

    assert_nor_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_load_i && alu_fn_i == 2'd2) |=> !carry_o);

    assert_store_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i == 2'd3 && alu_fn_i == 2'd0 && carry_in_n_i) |-> (bus_o == acc_o));

endmodule

// File: tb/nib_datapath_test.sv
module nib_datapath_test;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] imm_i = '0, mem_rdata_i = '0, port_i = '0;
    logic [1:0] alu_fn_i = '0, bus_sel_i = '0;
    logic       carry_in_n_i = 1'b1, acc_load_i = 1'b0, flags_load_i = 1'b0;
    logic [3:0] bus_o, acc_o;
    logic       carry_o, equal_o;

    int errors = 0;
    int checks = 0;
    int m_acc = 0, m_c = 0, m_e = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_datapath uut (
        .clk(clk), .rst_n(rst_n), .imm_i(imm_i), .mem_rdata_i(mem_rdata_i),
        .port_i(port_i), .alu_fn_i(alu_fn_i), .carry_in_n_i(carry_in_n_i),
        .acc_load_i(acc_load_i), .flags_load_i(flags_load_i), .bus_sel_i(bus_sel_i),
        .bus_o(bus_o), .acc_o(acc_o), .carry_o(carry_o), .equal_o(equal_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input string tag, input int fn, input int cin_n, input int sel,
                        input int accld, input int flld, input int imm, input int mem,
                        input int port);
        int src, b, s, res, co, ebus;
        imm_i = 4'(imm); mem_rdata_i = 4'(mem); port_i = 4'(port);
        alu_fn_i = 2'(fn); carry_in_n_i = 1'(cin_n); bus_sel_i = 2'(sel);
        acc_load_i = 1'(accld); flags_load_i = 1'(flld);
        src = (sel == 0) ? imm : (sel == 1) ? mem : (sel == 2) ? port : 0;
        b = (sel == 3) ? 0 : src;
        case (fn)
            0: s = m_acc + b + (1 - cin_n);
            1: s = m_acc + (15 - b) + (1 - cin_n);
            2: s = (~(m_acc | b)) & 15;
            default: s = b;
        endcase
        res = s & 15;
        co = (s >> 4) & 1;
        ebus = (sel == 3) ? res : src;
        #1;
        chk(tag, "bus", int'(bus_o), ebus);
        @(posedge clk);
        if (accld != 0 && fn != 1) m_acc = res;
        if (flld != 0) begin
            m_c = co;
            m_e = (res == 0) ? 1 : 0;
        end
        @(negedge clk);
        chk(tag, "acc", int'(acc_o), m_acc);
        chk(tag, "carry", int'(carry_o), m_c);
        chk(tag, "equal", int'(equal_o), m_e);
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "acc in reset", int'(acc_o), 0);
        chk("R1", "carry in reset", int'(carry_o), 0);
        chk("R1", "equal in reset", int'(equal_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "acc after reset", int'(acc_o), 0);

        // R2 / R6: each external source loads through pass
        for (int v = 0; v < 16; v++) begin
            step("R6", 3, 1, 0, 1, 0, v, 15 - v, v ^ 5);
            step("R2", 3, 1, 1, 1, 0, v ^ 3, v, 0);
            step("R2", 3, 1, 2, 1, 0, 0, 9, v);
        end

        // R3, R4, R5, R6, R7, R8: exhaustive sweep of accumulator x operand
        for (int fn = 0; fn < 4; fn++) begin
            for (int cn = 0; cn < 2; cn++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        string tg;
                        tg = (fn == 0) ? "R3" : (fn == 1) ? "R4" : (fn == 2) ? "R5" : "R6";
                        step("R6", 3, 1, 0, 1, 0, a, 0, 0);
                        if (b == 7) tg = "R8";
                        step(tg, fn, cn, 1, 1, (b == 7) ? 0 : 1, a ^ b, b, 0);
                    end
                end
            end
        end

        // R10: store path shows accumulator-only results; R9: acc holds
        for (int a = 0; a < 16; a++) begin
            step("R6", 3, 1, 0, 1, 0, a, 0, 0);
            step("R10", 0, 1, 3, 0, 0, 0, 4, 4);
            step("R10", 2, 1, 3, 0, 0, 0, 4, 4);
            step("R9", 0, 1, 2, 0, 1, 0, 0, 15 - a);
        end

        // R11: set carry, then add with carry-in off
        step("R6", 3, 1, 0, 1, 0, 15, 0, 0);
        step("R11", 0, 1, 0, 1, 1, 1, 0, 0);
        chk("R11", "carry set", int'(carry_o), 1);
        step("R11", 0, 1, 0, 1, 1, 2, 0, 0);
        chk("R11", "sum without stored carry", int'(acc_o), 2);

        // R4: compare with acc >= operand gives carry 1
        step("R6", 3, 1, 0, 1, 0, 6, 0, 0);
        step("R4", 1, 0, 0, 1, 1, 6, 0, 0);
        chk("R4", "equal on match", int'(equal_o), 1);
        chk("R4", "acc kept", int'(acc_o), 6);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule